// File: doc/BRIEF.md
# Status Packet Byte Transmitter

This block reports a status word of up to 26 bits to a downstream collector as a short packet on an 8-bit byte bus. When the surrounding logic pulses a trigger, the block captures the status word and a location selector. It then raises a request and drives the packet's address byte on the bus. The collector answers with a one-cycle start pulse that accepts the address byte. The block then puts the four payload bytes on the bus on consecutive clocks and returns the bus to zero.

Every packet carries a 6-bit rolling sequence number, so the collector can pair each report with the command that caused it. A single instance answers at four consecutive byte addresses, starting at a parameterised base. The 2-bit selector captured with the trigger picks the offset.

The design is a three-state machine:
- IDLE: the bus is zero.
- REQ: the request is high and the address byte is held on the bus.
- SEND: the four payload bytes go out.

The transitions are:
- IDLE→REQ on a trigger.
- REQ→SEND on start.
- SEND→IDLE after the fourth byte.
- SEND→REQ after the fourth byte when another packet is waiting.

A trigger that arrives while a packet is in flight is remembered as one pending request.

Top module: `status_pkt_tx`

## Requirements
- R1: After reset, `stat_rq` is 0, `stat_ad` is 0 and the sequence counter is 0, so the first packet carries sequence 0.
- R2: A `trig` pulse seen in IDLE makes `stat_rq` high from the next clock. `stat_ad` then shows `BASE_ADDR + loc_sel`, with `loc_sel` sampled together with `trig`.
- R3: While `stat_rq` is high and `stat_start` is low, `stat_rq` stays high on the next clock and `stat_ad` does not change.
- R4: `stat_start` seen while `stat_rq` is high makes `stat_rq` low from the next clock. The four payload bytes then appear on the next four consecutive clocks.
- R5: The payload bytes are sent in this order:
  - `{seq[5:0], status[1:0]}`, with the sequence in bits 7:2
  - `status[9:2]`
  - `status[17:10]`
  - `status[25:18]`
- R6: After the fourth payload byte, `stat_ad` returns to 0 unless another packet is pending.
- R7: The status word and location are captured in the cycle the trigger is accepted. Later changes on `status_in` or `loc_sel` do not alter the packet.
- R8: The sequence number goes up by one after each packet's last byte and wraps from 63 to 0.
- R9: A trigger during REQ or SEND is queued. The request for the queued packet is raised on the clock right after the current packet's last byte. Its status is captured in that last-byte cycle.
- R10: Any number of triggers during one packet produce exactly one queued packet.
- R11: `stat_start` has no effect when `stat_rq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trig | input | 1 | Pulse asking for a new status packet |
| loc_sel | input | 2 | Location offset added to the base address |
| status_in | input | 26 | Status word to report |
| stat_start | input | 1 | Acknowledge of the address byte |
| stat_rq | output | 1 | Request to send a packet |
| stat_ad | output | 8 | Byte bus carrying the address byte, then the payload |

## Verification
The bench changes `status_in` and `loc_sel` while a request waits. A design that sampled late would send the new value instead of the one captured at the trigger. It fires triggers in the last payload cycle and several times during one packet. A wrong queue would drop the follow-up request, send it twice, or leave a gap cycle before it. It runs more than 64 packets to reach the sequence wrap, and pulses start while idle to catch a design that begins a payload without a request.

// File: rtl/status_pkt_pkg.sv
package status_pkt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SEND = 2'd2
    } tx_state_e;
endpackage

// File: rtl/status_pkt_fmt.sv
module status_pkt_fmt
    import status_pkt_pkg::*;
#(
    parameter int STAT_W = 26,
    parameter int SEQ_W  = 6,
    parameter int IDX_W  = 2
) (
    input  tx_state_e            state,
    input  logic [IDX_W-1:0]     idx,
    input  logic [7:0]           addr_byte,
    input  logic [SEQ_W-1:0]     seq,
    input  logic [STAT_W-1:0]    shadow,
    output logic [7:0]           bus_byte
);
    localparam int LOW_W = 8 - SEQ_W;
    logic [31:0] padded;

    always_comb begin
        padded = '0;
        padded[STAT_W-1:0] = shadow;
    end

    always_comb begin
        bus_byte = 8'h00;
        unique case (state)
            ST_IDLE: bus_byte = 8'h00;
            ST_REQ:  bus_byte = addr_byte;
            ST_SEND: begin
                if (idx == '0)
                    bus_byte = {seq, padded[LOW_W-1:0]};
                else
                    bus_byte = padded[LOW_W + 8*(int'(idx)-1) +: 8];
            end
            default: bus_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/status_pkt_tx.sv
module status_pkt_tx
    import status_pkt_pkg::*;
#(
    parameter int         STAT_W    = 26,
    parameter int         SEQ_W     = 6,
    parameter logic [7:0] BASE_ADDR = 8'h20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trig,
    input  logic [1:0]        loc_sel,
    input  logic [STAT_W-1:0] status_in,
    input  logic              stat_start,
    output logic              stat_rq,
    output logic [7:0]        stat_ad
);
    localparam int PAY_BYTES = 4;
    localparam int IDX_W     = $clog2(PAY_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAY_BYTES - 1);

    tx_state_e          state;
    logic [IDX_W-1:0]   idx;
    logic [SEQ_W-1:0]   seq;
    logic               pend;
    logic [STAT_W-1:0]  shadow;
    logic [1:0]         loc;
    logic               last_byte;
    logic [7:0]         addr_byte;

    assign last_byte = (state == ST_SEND) && (idx == LAST_IDX);
    assign addr_byte = BASE_ADDR + {6'd0, loc};

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            seq    <= '0;
            pend   <= 1'b0;
            shadow <= '0;
            loc    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (trig) begin
                        state  <= ST_REQ;
                        shadow <= status_in;
                        loc    <= loc_sel;
                    end
                end
                ST_REQ: begin
                    if (trig) pend <= 1'b1;
                    if (stat_start) begin
                        state <= ST_SEND;
                        idx   <= '0;
                    end
                end
                ST_SEND: begin
                    idx <= idx + 1'b1;
                    if (idx == LAST_IDX) begin
                        seq <= seq + 1'b1;
                        if (pend || trig) begin
                            state  <= ST_REQ;
                            shadow <= status_in;
                            loc    <= loc_sel;
                            pend   <= 1'b0;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else if (trig) begin
                        pend <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    status_pkt_fmt #(
        .STAT_W (STAT_W),
        .SEQ_W  (SEQ_W),
        .IDX_W  (IDX_W)
    ) i_fmt (
        .state     (state),
        .idx       (idx),
        .addr_byte (addr_byte),
        .seq       (seq),
        .shadow    (shadow),
        .bus_byte  (stat_ad)
    );

    always_comb begin
        stat_rq = (state == ST_REQ);
    end

    // R3: request and address byte hold until acknowledged
    assert_rq_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (stat_rq && !stat_start) |=> (stat_rq && $stable(stat_ad)));

    // R4: acknowledge drops the request on the next clock
    assert_rq_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (stat_rq && stat_start) |=> !stat_rq);

    // R8: sequence advances by one after each last byte
    assert_seq_step_R8: assert property (@(posedge clk) disable iff (rst)
        last_byte |=> (seq == $past(seq) + 1'b1));

    // R11: start while idle does not begin a payload
    assert_start_idle_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && !trig) |=> (state == ST_IDLE));

    // R10: nothing is queued while idle
    assert_no_pend_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !pend);
endmodule

// File: tb/test_status_pkt_tx.sv
module test_status_pkt_tx;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] BASE       = 8'h20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        trig = 1'b0;
    logic [1:0]  loc_sel = 2'd0;
    logic [25:0] status_in = '0;
    logic        stat_start = 1'b0;
    logic        stat_rq;
    logic [7:0]  stat_ad;

    int    n_vec = 0;
    int    n_bad = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // behavioural reference
    int          ms = 0;        // 0 idle, 1 requesting, 2 payload
    int          mi = 0;
    int          mseq = 0;
    bit          mpend = 1'b0;
    logic [25:0] msh = '0;
    logic [1:0]  mloc = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    status_pkt_tx #(.BASE_ADDR(BASE)) i_status_pkt_tx (
        .clk(clk), .rst(rst), .trig(trig), .loc_sel(loc_sel),
        .status_in(status_in), .stat_start(stat_start),
        .stat_rq(stat_rq), .stat_ad(stat_ad)
    );

    always @(posedge clk) begin
        if (rst) begin
            ms = 0; mi = 0; mseq = 0; mpend = 0; msh = '0; mloc = '0;
        end else if (ms == 0) begin
            if (trig) begin ms = 1; msh = status_in; mloc = loc_sel; end
        end else if (ms == 1) begin
            if (trig) mpend = 1;
            if (stat_start) begin ms = 2; mi = 0; end
        end else begin
            if (mi == 3) begin
                mseq = (mseq + 1) % 64;
                if (mpend || trig) begin
                    ms = 1; msh = status_in; mloc = loc_sel; mpend = 0;
                end else ms = 0;
                mi = 0;
            end else begin
                mi = mi + 1;
                if (trig) mpend = 1;
            end
        end
    end

    function automatic logic [7:0] exp_ad();
        logic [5:0] s;
        s = mseq[5:0];
        if (ms == 1) return BASE + {6'd0, mloc};
        if (ms == 2) begin
            case (mi)
                0: return {s, msh[1:0]};
                1: return msh[9:2];
                2: return msh[17:10];
                default: return msh[25:18];
            endcase
        end
        return 8'h00;
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            n_vec++;
            if (stat_rq !== (ms == 1)) begin
                n_bad++;
                $display("FAIL %s stat_rq actual=%0b expected=%0b", tag, stat_rq, (ms == 1));
            end
            n_vec++;
            if (stat_ad !== exp_ad()) begin
                n_bad++;
                $display("FAIL %s stat_ad actual=%02h expected=%02h", tag, stat_ad, exp_ad());
            end
        end
    end

    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_trig(logic [25:0] st, logic [1:0] l);
        status_in = st; loc_sel = l; trig = 1'b1;
        cyc(); trig = 1'b0;
    endtask

    task automatic pulse_start();
        stat_start = 1'b1; cyc(); stat_start = 1'b0;
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        tag = "R1";
        cyc(2);
        // R2 R3 R5 R7: capture and hold while status input changes
        tag = "R2/R3/R5/R7";
        pulse_trig(26'h2ABCDEF, 2'd2);
        status_in = 26'h1555555; loc_sel = 2'd1;
        cyc(3);
        tag = "R4/R5/R6";
        pulse_start();
        cyc(6);
        // R11: start while idle
        tag = "R11";
        pulse_start();
        cyc(3);
        // R9 R10: triggers during request and payload
        tag = "R9/R10";
        pulse_trig(26'h0F0F0F3, 2'd3);
        trig = 1'b1; status_in = 26'h3000001; cyc(); trig = 1'b0;
        pulse_start();
        trig = 1'b1; cyc(2); trig = 1'b0;
        status_in = 26'h1234567; loc_sel = 2'd0;
        cyc(3);
        pulse_start();
        cyc(6);
        // R9: trigger exactly in the last payload cycle
        tag = "R9";
        pulse_trig(26'h0000AAA, 2'd1);
        pulse_start();
        cyc(3);
        pulse_trig(26'h3FFFFFF, 2'd2);
        cyc(1);
        pulse_start();
        cyc(6);
        // R8: run past the sequence wrap
        tag = "R8";
        for (int k = 0; k < 70; k++) begin
            pulse_trig(26'(k * 32'h9E3779), 2'(k));
            pulse_start();
            cyc(5);
        end
        cyc(2);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule